// File: doc/BRIEF.md
# Color LCD Controller Register Interface

This block is the register slave of a color LCD controller. It sits on a 32-bit bus that addresses whole words inside a 4 KB window. The bus carries the word index (byte offset >> 2) on `busAddr`. The block holds the panel timing words, the two frame base pointers, the control word, an interrupt mask and a raw interrupt status. It also decodes a 128-word palette window, which is handed to an external palette store, and a read-only identification area.

The block turns the timing writes into the active panel width and height. From the control word it exports the display enable and the pixel depth code. After every write it gives a one-cycle invalidate pulse, so the display update logic knows that its picture may be stale.

A strap input, `altMap`, serves one board variant by exchanging the offsets of the control and mask registers. Read data is combinational and is valid while `busSel` is high. The error pulse and the invalidate pulse are registered and appear in the cycle after the access.

Top module: `lcdc_regif`

## Requirements
- R1: After reset every register reads zero. `panelWidth`, `panelHeight`, `dispEnable`, `depthCode`, `irqOut`, `invalidate` and `errPulse` are all zero.
- R2: Timing words 0..3 are read and written at word indices 0..3 (byte offsets 0x00-0x0C). The upper base is at index 4 (0x10) and the lower base at index 5 (0x14). Index 11 (0x2C) reads back the upper base and index 12 (0x30) reads back the lower base.
- R3: A write to timing word 0 sets `panelWidth` to ((value & 0xFC) + 4) * 4. A write to timing word 1 sets `panelHeight` to (value & 0x3FF) + 1. Each result is visible in the cycle after the write, and the full written word still reads back.
- R4: The control word uses these bits: bit 0 is enable, bits 3:1 are the depth code (driven on `depthCode`), bit 8 selects BGR order, bit 9 selects big-endian bytes, bit 10 selects big-endian pixels and bit 11 is power. `dispEnable` is high only when bit 0 and bit 11 are both set.
- R5: With `altMap` low, the mask is at index 6 (0x18) and control is at index 7 (0x1C). With `altMap` high the two offsets are exchanged.
- R6: Each high bit of `intSet` sets the matching raw status bit, which reads at index 8 (0x20). Index 9 (0x24) reads raw AND mask. A write to index 10 (0x28) clears the raw bits that are set in the written value, but a set in the same cycle takes priority. `irqOut` is the OR of the masked bits.
- R7: Indices 0x80-0xFF (bytes 0x200-0x3FC) form the palette window. While the access is under way, `palIdx` is the index minus 0x80. A write drives `palWe` with `palWdata` equal to the bus data. A read returns `palRdata` unchanged.
- R8: Indices 0x3F8-0x3FF (bytes 0xFE0-0xFFC) read the bytes 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, one per word, zero-extended.
- R9: An undefined index reads zero and ignores a write. The same holds for a write to a read-only index and a read of the clear index. Each such access raises `errPulse` for the single following cycle.
- R10: Every write, palette and undefined writes included, raises `invalidate` for exactly the following cycle. A read does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| altMap | input | 1 | Board variant strap: exchanges the control and mask offsets |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 10 | Word index inside the 4 KB window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| errPulse | output | 1 | One-cycle pulse after an undefined access |
| palWe | output | 1 | Palette write strobe |
| palIdx | output | 7 | Palette entry index |
| palWdata | output | 32 | Palette write data |
| palRdata | input | 32 | Palette read data from the external store |
| intSet | input | IRQ_W | Raw status set requests |
| irqOut | output | 1 | OR of the masked status bits |
| dispEnable | output | 1 | Enable and power both set |
| depthCode | output | 3 | Pixel depth code from the control word |
| invalidate | output | 1 | One-cycle pulse after any write |
| panelWidth | output | 11 | Active width in pixels |
| panelHeight | output | 11 | Active height in lines |

## Verification
The bench builds the block with `IRQ_W` = 4, so it can set, mask and clear every status bit one by one. It covers the smallest and the largest width and height that the timing fields can encode (16 and 1024 pixels, 1 and 1024 lines). It runs the register map once with the strap low and once with it high, which shows that the control and mask storage stay the same and only their offsets move. A set request and a clear of the same status bit in one cycle shows which of the two wins.

// File: rtl/lcdc_regif_pkg.sv
package lcdc_regif_pkg;

  localparam int WORD_AW = 10;

  typedef enum logic [3:0] {
    RD_NONE, RD_TIM, RD_UPB, RD_LOB, RD_MASK, RD_CTRL,
    RD_RAW, RD_MIS, RD_PAL, RD_ID
  } rdSel_e;

  typedef struct packed {
    logic [3:0] wrTiming;
    logic       wrUpBase;
    logic       wrLoBase;
    logic       wrMask;
    logic       wrCtrl;
    logic       wrClear;
    logic       wrPal;
    logic       anyWr;
    logic       badAcc;
    rdSel_e     rdSel;
    logic [2:0] subIdx;
  } strobe_t;

  function automatic logic [7:0] idByte(input logic [2:0] i);
    case (i)
      3'd0: idByte = 8'h10;
      3'd1: idByte = 8'h11;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcdc_regif_ctrl.sv
module lcdc_regif_ctrl
  import lcdc_regif_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               altMap,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [WORD_AW-1:0] busAddr,
  output strobe_t            stb,
  output logic               errPulse
);

  logic [WORD_AW-1:0] maskWord, ctrlWord;
  logic inPal, inId, isWr, isRd;

  assign maskWord = altMap ? WORD_AW'(7) : WORD_AW'(6);
  assign ctrlWord = altMap ? WORD_AW'(6) : WORD_AW'(7);
  assign inPal = (busAddr[WORD_AW-1:7] == 3'b001);
  assign inId  = (busAddr[WORD_AW-1:3] == 7'h7F);
  assign isWr  = busSel && busWrite;
  assign isRd  = busSel && !busWrite;

  always_comb begin
    stb = '0;
    stb.rdSel  = RD_NONE;
    stb.subIdx = busAddr[2:0];
    stb.anyWr  = isWr;
    if (busSel) begin
      if (inPal) begin
        stb.wrPal = isWr;
        if (isRd) stb.rdSel = RD_PAL;
      end else if (inId) begin
        if (isRd) stb.rdSel = RD_ID;
        else stb.badAcc = 1'b1;
      end else if (busAddr < WORD_AW'(4)) begin
        if (isWr) stb.wrTiming = 4'b0001 << busAddr[1:0];
        else stb.rdSel = RD_TIM;
      end else if (busAddr == maskWord) begin
        if (isWr) stb.wrMask = 1'b1;
        else stb.rdSel = RD_MASK;
      end else if (busAddr == ctrlWord) begin
        if (isWr) stb.wrCtrl = 1'b1;
        else stb.rdSel = RD_CTRL;
      end else begin
        case (busAddr)
          WORD_AW'(4): if (isWr) stb.wrUpBase = 1'b1; else stb.rdSel = RD_UPB;
          WORD_AW'(5): if (isWr) stb.wrLoBase = 1'b1; else stb.rdSel = RD_LOB;
          WORD_AW'(8): if (isRd) stb.rdSel = RD_RAW; else stb.badAcc = 1'b1;
          WORD_AW'(9): if (isRd) stb.rdSel = RD_MIS; else stb.badAcc = 1'b1;
          WORD_AW'(10): if (isWr) stb.wrClear = 1'b1; else stb.badAcc = 1'b1;
          WORD_AW'(11): if (isRd) stb.rdSel = RD_UPB; else stb.badAcc = 1'b1;
          WORD_AW'(12): if (isRd) stb.rdSel = RD_LOB; else stb.badAcc = 1'b1;
          default: stb.badAcc = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errPulse <= 1'b0;
    else errPulse <= stb.badAcc;
  end

  // R9
  err_needs_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(busSel));

  // R9
  err_follows_bad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !inPal && !inId && busAddr > WORD_AW'(12)) |=> errPulse);

endmodule

// File: rtl/lcdc_regif_dp.sv
module lcdc_regif_dp
  import lcdc_regif_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [31:0]      wdata,
  input  logic [31:0]      palRdata,
  input  logic [IRQ_W-1:0] intSet,
  output logic [31:0]      rdata,
  output logic             irqOut,
  output logic             dispEnable,
  output logic [2:0]       depthCode,
  output logic             invalidate,
  output logic [10:0]      panelWidth,
  output logic [10:0]      panelHeight
);

  localparam int CTRL_EN  = 0;
  localparam int CTRL_PWR = 11;

  logic [31:0]      timing [4];
  logic [31:0]      upBase, loBase, ctrlReg;
  logic [IRQ_W-1:0] maskReg, rawReg, misBits;

  for (genvar t = 0; t < 4; t++) begin : g_tim
    always_ff @(posedge clk) begin
      if (!rstN) timing[t] <= '0;
      else if (stb.wrTiming[t]) timing[t] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upBase <= '0;
      loBase <= '0;
      ctrlReg <= '0;
      maskReg <= '0;
      rawReg <= '0;
      panelWidth <= '0;
      panelHeight <= '0;
      invalidate <= 1'b0;
    end else begin
      invalidate <= stb.anyWr;
      if (stb.wrUpBase) upBase <= wdata;
      if (stb.wrLoBase) loBase <= wdata;
      if (stb.wrCtrl) ctrlReg <= wdata;
      if (stb.wrMask) maskReg <= wdata[IRQ_W-1:0];
      if (stb.wrClear) rawReg <= (rawReg & ~wdata[IRQ_W-1:0]) | intSet;
      else rawReg <= rawReg | intSet;
      if (stb.wrTiming[0]) panelWidth <= {1'b0, wdata[7:2], 4'b0000} + 11'd16;
      if (stb.wrTiming[1]) panelHeight <= {1'b0, wdata[9:0]} + 11'd1;
    end
  end

  assign misBits    = rawReg & maskReg;
  assign irqOut     = |misBits;
  assign dispEnable = ctrlReg[CTRL_EN] & ctrlReg[CTRL_PWR];
  assign depthCode  = ctrlReg[3:1];

  always_comb begin
    case (stb.rdSel)
      RD_TIM:  rdata = timing[stb.subIdx[1:0]];
      RD_UPB:  rdata = upBase;
      RD_LOB:  rdata = loBase;
      RD_MASK: rdata = 32'(maskReg);
      RD_CTRL: rdata = ctrlReg;
      RD_RAW:  rdata = 32'(rawReg);
      RD_MIS:  rdata = 32'(misBits);
      RD_PAL:  rdata = palRdata;
      RD_ID:   rdata = {24'h0, idByte(stb.subIdx)};
      default: rdata = '0;
    endcase
  end

  // R10
  inval_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.anyWr |=> invalidate);

  // R3
  width_derive_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrTiming[0] |=> panelWidth == 11'((32'($past(wdata[7:2])) + 1) * 16));

  // R4
  enable_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCtrl |=> dispEnable == ($past(wdata[0]) && $past(wdata[11])));

  // R6
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrClear && intSet == '0) |=> (rawReg & $past(wdata[IRQ_W-1:0])) == '0);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intSet != '0) |=> (rawReg & $past(intSet)) == $past(intSet));

endmodule

// File: rtl/lcdc_regif.sv
module lcdc_regif
  import lcdc_regif_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             altMap,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [9:0]       busAddr,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  output logic             errPulse,
  output logic             palWe,
  output logic [6:0]       palIdx,
  output logic [31:0]      palWdata,
  input  logic [31:0]      palRdata,
  input  logic [IRQ_W-1:0] intSet,
  output logic             irqOut,
  output logic             dispEnable,
  output logic [2:0]       depthCode,
  output logic             invalidate,
  output logic [10:0]      panelWidth,
  output logic [10:0]      panelHeight
);

  strobe_t stb;

  lcdc_regif_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .altMap(altMap), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .stb(stb), .errPulse(errPulse)
  );

  lcdc_regif_dp #(.IRQ_W(IRQ_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .palRdata(palRdata),
    .intSet(intSet), .rdata(busRdata), .irqOut(irqOut), .dispEnable(dispEnable),
    .depthCode(depthCode), .invalidate(invalidate), .panelWidth(panelWidth),
    .panelHeight(panelHeight)
  );

  assign palWe    = stb.wrPal;
  assign palIdx   = busAddr[6:0];
  assign palWdata = busWdata;

endmodule

// File: tb/sim_lcdc_regif.sv
`timescale 1ns/1ps
module sim_lcdc_regif;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic altMap = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [9:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, palWdata, palRdata;
  logic errPulse, palWe, irqOut, dispEnable, invalidate;
  logic [6:0] palIdx;
  logic [3:0] intSet = '0;
  logic [2:0] depthCode;
  logic [10:0] panelWidth, panelHeight;

  int checks = 0, errors = 0;
  bit done = 0;
  logic lastInv, lastErr, seenWe;
  logic [6:0] seenIdx;
  logic [31:0] seenWd;

  always #2 clk = ~clk;

  assign palRdata = {8'hC3, 17'h0, palIdx};

  lcdc_regif u0 (
    .clk(clk), .rstN(rstN), .altMap(altMap), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .errPulse(errPulse), .palWe(palWe), .palIdx(palIdx),
    .palWdata(palWdata), .palRdata(palRdata), .intSet(intSet), .irqOut(irqOut),
    .dispEnable(dispEnable), .depthCode(depthCode), .invalidate(invalidate),
    .panelWidth(panelWidth), .panelHeight(panelHeight)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    #0.5;
    seenWe = palWe; seenIdx = palIdx; seenWd = palWdata;
    @(posedge clk); #1;
    lastInv = invalidate; lastErr = errPulse;
    busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #0.5;
    d = busRdata; seenWe = palWe;
    @(posedge clk); #1;
    lastInv = invalidate; lastErr = errPulse;
    busSel = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 width", 32'(panelWidth), 0);
    chk("R1 height", 32'(panelHeight), 0);
    chk("R1 enable", 32'(dispEnable), 0);
    chk("R1 irq", 32'(irqOut), 0);
    chk("R1 inval", 32'(invalidate), 0);
    chk("R1 err", 32'(errPulse), 0);
    rd(10'd7, v); chk("R1 ctrl", v, 0);
    rd(10'd4, v); chk("R1 upbase", v, 0);
    rd(10'd8, v); chk("R1 raw", v, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(10'd2, 32'h12345678); rd(10'd2, v); chk("R2 timing2", v, 32'h12345678);
    wr(10'd3, 32'hCAFEF00D); rd(10'd3, v); chk("R2 timing3", v, 32'hCAFEF00D);
    wr(10'd4, 32'h80001000); rd(10'd4, v); chk("R2 upbase", v, 32'h80001000);
    rd(10'd11, v); chk("R2 upcur", v, 32'h80001000);
    wr(10'd5, 32'h00200040); rd(10'd5, v); chk("R2 lobase", v, 32'h00200040);
    rd(10'd12, v); chk("R2 locur", v, 32'h00200040);
  endtask

  task automatic t_geom();
    logic [31:0] v;
    wr(10'd0, 32'h000000FF); chk("R3 width max", 32'(panelWidth), 1024);
    wr(10'd0, 32'hFFFFFF03); chk("R3 width min", 32'(panelWidth), 16);
    rd(10'd0, v); chk("R3 timing0 readback", v, 32'hFFFFFF03);
    wr(10'd0, 32'h0000009C); chk("R3 width 640", 32'(panelWidth), 640);
    wr(10'd1, 32'hFFFFF3FF); chk("R3 height max", 32'(panelHeight), 1024);
    wr(10'd1, 32'h00000400); chk("R3 height min", 32'(panelHeight), 1);
    wr(10'd1, 32'h000001DF); chk("R3 height 480", 32'(panelHeight), 480);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(10'd7, 32'h00000001); chk("R4 en only", 32'(dispEnable), 0);
    wr(10'd7, 32'h00000800); chk("R4 pwr only", 32'(dispEnable), 0);
    wr(10'd7, 32'h0000070B); chk("R4 order bits no pwr", 32'(dispEnable), 0);
    chk("R4 depth", 32'(depthCode), 5);
    wr(10'd7, 32'h00000807); chk("R4 both", 32'(dispEnable), 1);
    chk("R4 depth 3", 32'(depthCode), 3);
    rd(10'd7, v); chk("R4 ctrl readback", v, 32'h00000807);
  endtask

  task automatic t_alt();
    logic [31:0] v;
    wr(10'd7, 32'h0); wr(10'd6, 32'h0);
    altMap = 1;
    wr(10'd6, 32'h00000801); chk("R5 ctrl at 0x18", 32'(dispEnable), 1);
    wr(10'd7, 32'h00000003);
    rd(10'd7, v); chk("R5 mask at 0x1C", v, 3);
    rd(10'd6, v); chk("R5 ctrl read 0x18", v, 32'h801);
    altMap = 0;
    rd(10'd6, v); chk("R5 mask normal", v, 3);
    rd(10'd7, v); chk("R5 ctrl normal", v, 32'h801);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(10'd6, 32'h4);
    @(negedge clk); intSet = 4'h5; @(posedge clk); #1 intSet = 0;
    rd(10'd8, v); chk("R6 raw", v, 5);
    rd(10'd9, v); chk("R6 masked", v, 4);
    chk("R6 irq on", 32'(irqOut), 1);
    wr(10'd10, 32'h4);
    rd(10'd8, v); chk("R6 raw after clear", v, 1);
    chk("R6 irq off", 32'(irqOut), 0);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 10'd10; busWdata = 32'h1; intSet = 4'h1;
    @(posedge clk); #1 busSel = 0; busWrite = 0; intSet = 0;
    rd(10'd8, v); chk("R6 set beats clear", v, 1);
    wr(10'd10, 32'hF); rd(10'd8, v); chk("R6 clear all", v, 0);
  endtask

  task automatic t_pal();
    logic [31:0] v;
    wr(10'h085, 32'hA5A5_1234);
    chk("R7 we", 32'(seenWe), 1);
    chk("R7 idx", 32'(seenIdx), 5);
    chk("R7 wdata", seenWd, 32'hA5A5_1234);
    chk("R10 pal write inval", 32'(lastInv), 1);
    rd(10'h0FF, v); chk("R7 read", v, {8'hC3, 17'h0, 7'h7F});
    chk("R7 no we on read", 32'(seenWe), 0);
    wr(10'd4, 32'h1); chk("R7 no we outside", 32'(seenWe), 0);
  endtask

  task automatic t_id();
    logic [31:0] v;
    logic [7:0] exp [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      rd(10'h3F8 + 10'(i), v); chk("R8 id", v, 32'(exp[i]));
    end
  endtask

  task automatic t_bad();
    logic [31:0] v;
    rd(10'd13, v); chk("R9 undef read zero", v, 0);
    chk("R9 undef read err", 32'(lastErr), 1);
    @(posedge clk); #1 chk("R9 err one cycle", 32'(errPulse), 0);
    rd(10'h100, v); chk("R9 gap read zero", v, 0);
    rd(10'd10, v); chk("R9 clear read err", 32'(lastErr), 1);
    rd(10'd4, v); chk("R9 good read no err", 32'(lastErr), 0);
    @(negedge clk); intSet = 4'h2; @(posedge clk); #1 intSet = 0;
    wr(10'd8, 32'h0); chk("R9 ro write err", 32'(lastErr), 1);
    rd(10'd8, v); chk("R9 ro write ignored", v, 2);
    wr(10'd13, 32'hFFFF_FFFF); chk("R9 undef write err", 32'(lastErr), 1);
    chk("R10 undef write inval", 32'(lastInv), 1);
    rd(10'd0, v); chk("R9 timing untouched", v, 32'h9C);
    chk("R10 read no inval", 32'(lastInv), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_map();
    t_geom();
    t_ctrl();
    t_alt();
    t_irq();
    t_pal();
    t_id();
    t_bad();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule